// File: doc/BRIEF.md
# Selectable-Rate Input Noise Filter

This block cleans up an asynchronous external pin, such as a capture trigger or an interrupt request, before timer logic acts on it. The raw pin first crosses into the system clock domain through a two-flop synchronizer. A 2-bit rate select then decides how the synchronized value is used. In bypass it passes straight through. In the three filtered modes it is sampled on every clock, on a divide-by-8 enable, or on a divide-by-32 enable. A prescaler outside the block supplies both enables.

In the filtered modes, a short history of samples is kept. The output level moves to a new value only when the three most recent samples all show that value. Pulses shorter than three sample periods are therefore rejected. Whenever the select value changes, the history is reloaded with the current output level, so samples taken under the old rate cannot complete a transition under the new one. One-clock rising and falling pulses are derived from the filtered level for downstream edge logic.

Top module: `pin_glitch_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, `level_out`, `rise_pulse` and `fall_pulse` are all 0. The stored select value resets to bypass (00) and the sample history resets to all zeros.
- R2: With `rate_sel` = 00 held, `level_out` equals `pin_raw` delayed by exactly three clock edges (two synchronizer flops plus the level register).
- R3: With `rate_sel` = 01 held, one synchronized sample is taken on every clock edge.
- R4: With `rate_sel` = 10 held, a sample is taken only on edges where `tick8` is 1, and `level_out` cannot change after an edge where `tick8` was 0.
- R5: With `rate_sel` = 11 held, a sample is taken only on edges where `tick32` is 1, and `level_out` cannot change after an edge where `tick32` was 0.
- R6: In a filtered mode, `level_out` takes a new value on the sampling edge whose sample completes three consecutive samples of that value. A run of one or two differing samples leaves it unchanged.
- R7: On an edge where `rate_sel` differs from its value at the previous edge, no sample is taken and `level_out` holds. Every history entry is set to the current `level_out`, even if a sampling enable is high on that edge.
- R8: `rise_pulse` is 1 for exactly the one cycle after `level_out` goes from 0 to 1.
- R9: `fall_pulse` is 1 for exactly the one cycle after `level_out` goes from 1 to 0.
- R10: `rise_pulse` and `fall_pulse` are never both 1, and neither is 1 while `level_out` is unchanged from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external pin |
| rate_sel | input | 2 | 00 bypass, 01 every clock, 10 on tick8, 11 on tick32 |
| tick8 | input | 1 | One-cycle enable once every 8 clocks from the prescaler |
| tick32 | input | 1 | One-cycle enable once every 32 clocks from the prescaler |
| level_out | output | 1 | Filtered level |
| rise_pulse | output | 1 | One-clock pulse after a 0-to-1 change of level_out |
| fall_pulse | output | 1 | One-clock pulse after a 1-to-0 change of level_out |

## Verification
A change of `rate_sel` can land on the same edge as a sampling enable. There the history reload and the sample shift compete, and the reload must win. The bench provokes this directly: it feeds two agreeing samples, switches to the slow rate, and checks that the level has not moved 40 cycles later. It also provokes it at random, because segment boundaries fall freely against the free-running tick counters. Each case is judged cycle by cycle against a reference model that drops the sample on a change edge.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    typedef enum logic [1:0] {
        RATE_BYPASS = 2'b00,
        RATE_EVERY  = 2'b01,
        RATE_DIV8   = 2'b10,
        RATE_DIV32  = 2'b11
    } rate_e;

    localparam int SYNC_DEPTH_DEF = 2;
    localparam int VOTE_LEN_DEF   = 3;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } flt_out_t;

    // chooses the sampling strobe for a rate
    function automatic logic rate_strobe(input rate_e r, input logic t8, input logic t32);
        case (r)
            RATE_EVERY: return 1'b1;
            RATE_DIV8:  return t8;
            RATE_DIV32: return t32;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[DEPTH-2:0], d_async};
    end

    assign q_sync = chain_q[DEPTH-1];
endmodule

// File: rtl/pgf_strobe.sv
module pgf_strobe
    import pgf_pkg::*;
(
    input  rate_e rate,
    input  logic  tick8,
    input  logic  tick32,
    output logic  take_sample,
    output logic  pass_thru
);
    always_comb begin
        take_sample = rate_strobe(rate, tick8, tick32);
        pass_thru   = (rate == RATE_BYPASS);
    end
endmodule

// File: rtl/pgf_vote.sv
module pgf_vote #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_in,
    input  logic take_sample,
    input  logic pass_thru,
    input  logic reload,
    output logic level
);
    logic [LEN-1:0] hist_q;
    logic [LEN-1:0] hist_n;
    logic           lvl_q;

    always_comb hist_n = {hist_q[LEN-2:0], smp_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            lvl_q  <= 1'b0;
        end else if (reload) begin
            hist_q <= {LEN{lvl_q}};
        end else if (pass_thru) begin
            lvl_q  <= smp_in;
        end else if (take_sample) begin
            hist_q <= hist_n;
            if (hist_n == {LEN{smp_in}}) lvl_q <= smp_in;
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
    import pgf_pkg::*;
#(
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF,
    parameter int VOTE_LEN   = VOTE_LEN_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_raw,
    input  logic [1:0] rate_sel,
    input  logic       tick8,
    input  logic       tick32,
    output logic       level_out,
    output logic       rise_pulse,
    output logic       fall_pulse
);
    rate_e    rate_cur;
    rate_e    rate_prev_q;
    logic     pin_sync;
    logic     take_sample;
    logic     pass_thru;
    logic     reload;
    logic     lvl;
    logic     lvl_d_q;
    flt_out_t outs;

    assign rate_cur = rate_e'(rate_sel);

    pgf_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_raw),
        .q_sync  (pin_sync)
    );

    pgf_strobe u_strobe (
        .rate        (rate_cur),
        .tick8       (tick8),
        .tick32      (tick32),
        .take_sample (take_sample),
        .pass_thru   (pass_thru)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_prev_q <= RATE_BYPASS;
            lvl_d_q     <= 1'b0;
        end else begin
            rate_prev_q <= rate_cur;
            lvl_d_q     <= lvl;
        end
    end

    assign reload = (rate_cur != rate_prev_q);

    pgf_vote #(.LEN(VOTE_LEN)) u_vote (
        .clk         (clk),
        .rst         (rst),
        .smp_in      (pin_sync),
        .take_sample (take_sample),
        .pass_thru   (pass_thru),
        .reload      (reload),
        .level       (lvl)
    );

    always_comb begin
        outs.level = lvl;
        outs.rise  = lvl & ~lvl_d_q;
        outs.fall  = ~lvl & lvl_d_q;
    end

    assign level_out  = outs.level;
    assign rise_pulse = outs.rise;
    assign fall_pulse = outs.fall;
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker (
    input logic       clk,
    input logic       rst,
    input logic       pin_raw,
    input logic [1:0] rate_sel,
    input logic       tick8,
    input logic       tick32,
    input logic       level_out,
    input logic       rise_pulse,
    input logic       fall_pulse
);
    logic [1:0] up_cnt;

    always_ff @(posedge clk) begin
        if (rst)                up_cnt <= 2'd0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    p_bypass_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (up_cnt == 2'd3 && rate_sel == 2'b00 && $past(rate_sel) == 2'b00)
        |=> (level_out == $past(pin_raw, 3)));

    p_div8_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'b10 && !tick8) |=> $stable(level_out));

    p_div32_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'b11 && !tick32) |=> $stable(level_out));

    p_sel_change_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (up_cnt != 2'd0 && rate_sel != $past(rate_sel)) |=> $stable(level_out));

    p_rise_shape_r8: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |-> (level_out && !$past(level_out)));

    p_fall_shape_r9: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |-> (!level_out && $past(level_out)));

    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(rise_pulse && fall_pulse));

    p_no_pulse_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (up_cnt != 2'd0 && level_out == $past(level_out)) |-> !(rise_pulse || fall_pulse));
endmodule

bind pin_glitch_filter pgf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_raw    (pin_raw),
    .rate_sel   (rate_sel),
    .tick8      (tick8),
    .tick32     (tick32),
    .level_out  (level_out),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse)
);

// File: tb/pin_glitch_filter_bench.sv
module pin_glitch_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       pin_raw;
    logic [1:0] rate_sel;
    logic       tick8;
    logic       tick32;
    logic       level_out;
    logic       rise_pulse;
    logic       fall_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_cnt = 0;
    bit done     = 0;
    string force_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_glitch_filter u_pin_glitch_filter (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (pin_raw),
        .rate_sel   (rate_sel),
        .tick8      (tick8),
        .tick32     (tick32),
        .level_out  (level_out),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    // reference model built from the requirements
    logic       m_s1, m_s2, m_lvl, m_lvl_d;
    logic [2:0] m_hist, m_nh;
    logic [1:0] m_prev;

    function automatic logic ref_strobe(input logic [1:0] s, input logic t8, input logic t32);
        if (s == 2'b01) return 1'b1;
        if (s == 2'b10) return t8;
        if (s == 2'b11) return t32;
        return 1'b0;
    endfunction

    function automatic logic ref_agree(input logic [2:0] h);
        return (h == 3'b000) || (h == 3'b111);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_lvl <= 0; m_lvl_d <= 0;
            m_hist <= 3'b000; m_prev <= 2'b00;
        end else begin
            m_s1    <= pin_raw;
            m_s2    <= m_s1;
            m_lvl_d <= m_lvl;
            m_prev  <= rate_sel;
            if (rate_sel != m_prev) begin
                m_hist <= {3{m_lvl}};
            end else if (rate_sel == 2'b00) begin
                m_lvl <= m_s2;
            end else if (ref_strobe(rate_sel, tick8, tick32)) begin
                m_nh = {m_hist[1:0], m_s2};
                m_hist <= m_nh;
                if (ref_agree(m_nh)) m_lvl <= m_s2;
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] s);
        if (force_tag != "") return force_tag;
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3/R6";
            2'b10:   return "R4/R6";
            default: return "R5/R6";
        endcase
    endfunction

    task automatic compare_all();
        if (!rst) begin
            chk(level_out, m_lvl, mode_tag(rate_sel));
            chk(rise_pulse, m_lvl & ~m_lvl_d, "R8");
            chk(fall_pulse, ~m_lvl & m_lvl_d, "R9");
            chk(rise_pulse & fall_pulse, 1'b0, "R10");
        end
    endtask

    task automatic cyc(input logic p, input logic [1:0] s);
        @(negedge clk);
        compare_all();
        pin_raw  = p;
        rate_sel = s;
        tick8    = (tick_cnt % 8) == 7;
        tick32   = (tick_cnt % 32) == 31;
        tick_cnt++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; pin_raw = 0; rate_sel = 2'b00; tick8 = 0; tick32 = 0;
        repeat (4) @(negedge clk);
        chk(level_out, 1'b0, "R1");
        chk(rise_pulse, 1'b0, "R1");
        chk(fall_pulse, 1'b0, "R1");
        rst = 0;
        @(negedge clk);
        chk(level_out, 1'b0, "R1");
        chk(rise_pulse | fall_pulse, 1'b0, "R1");

        // R2: bypass follows pin after three edges
        for (int i = 0; i < 20; i++) cyc(i[2], 2'b00);
        repeat (6) cyc(1'b0, 2'b00);

        // R6: a two-sample glitch is rejected at the every-clock rate
        repeat (10) cyc(1'b0, 2'b01);
        repeat (2) cyc(1'b1, 2'b01);
        repeat (12) cyc(1'b0, 2'b01);
        chk(level_out, 1'b0, "R6 glitch");
        repeat (8) cyc(1'b1, 2'b01);
        chk(level_out, 1'b1, "R6 accept");
        repeat (10) cyc(1'b0, 2'b01);
        chk(level_out, 1'b0, "R6 accept low");

        // R7: two agreeing samples, then switch to the slow rate
        force_tag = "R7";
        repeat (4) cyc(1'b1, 2'b01);
        repeat (40) cyc(1'b1, 2'b11);
        chk(level_out, 1'b0, "R7 history cleared");
        force_tag = "";
        repeat (100) cyc(1'b1, 2'b11);
        chk(level_out, 1'b1, "R5 slow accept");

        // random segments mixed across rates
        for (int seg = 0; seg < 300; seg++) begin
            logic [1:0] s;
            int len;
            s   = 2'($urandom % 4);
            len = 20 + int'($urandom % 180);
            while (len > 0) begin
                logic p;
                int hold;
                p    = 1'($urandom % 2);
                hold = 1 + int'($urandom % ((s == 2'b11) ? 120 : 14));
                for (int k = 0; k < hold && len > 0; k++) begin
                    cyc(p, s);
                    len--;
                end
            end
        end
        cyc(1'b0, 2'b00);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule